// File: doc/BRIEF.md
# Real-Time Seconds Counter with Alarm

The block counts elapsed time in units set by a programmable prescaler. A slow-clock enable pulse (`slow_tick_i`) arrives at the block's clock rate. Each pulse advances a prescaler phase counter. When the phase counter completes one divisor period, the main up counter advances by one. The main counter wraps to zero after its all-ones value. With the default parameters the divisor resets to 0x8000, so a 32.768 kHz tick enable gives one count per second. The 20-bit counter then rolls over after a little more than twelve days.

Software writes the divisor, the alarm value and an interrupt enable mask through a simple write port. Writing the divisor restarts both the prescaler and the counter. The count, the sticky status flags, the divisor and the alarm are read combinationally through a read port, and a status read clears the flags. The block has two flag sources:
- an increment flag, which is set on every advance, so it can act as a periodic interrupt;
- an alarm flag, which is set when the counter steps onto the alarm value.

The interrupt output combines the flags with their enables.

Top module: `seconds_counter`

## Requirements
- R1: After reset the count reads 0, both flags read 0, irq_o is low, the divisor reads PRE_RST (default 0x8000) and the alarm reads all ones in CNT_W bits (default 0xFFFFF).
- R2: The count advances by one only on a cycle with slow_tick_i high that completes a divisor period of D ticks. Cycles with slow_tick_i low change neither the count nor the prescaler phase.
- R3: A divisor value of 0 gives a period of 2^PRE_W ticks (65536 by default).
- R4: The count wraps from all ones to 0 on the next advance.
- R5: A write to address 0 (divisor) loads the divisor and clears both the prescaler phase and the count. A tick in the same cycle as that write is lost.
- R6: Status bit 0 (increment flag) is set at every advance of the count.
- R7: Status bit 1 (alarm flag) is set only when an advance makes the count equal to the alarm register. A count that stays at the alarm value does not set the flag again.
- R8: Both flags are sticky. A read of address 1 with rd_en_i high clears them at that clock edge, and a flag set in the same cycle as the clear stays set.
- R9: irq_o is high exactly when some status bit is set and its enable bit is also set. The enable bits are written at address 2, data bits [1:0], with bit 0 for the increment flag and bit 1 for the alarm flag.
- R10: Read address 0 returns the count, address 1 the flags in bits [1:0], address 2 the divisor and address 3 the alarm, all zero-extended. These reads are valid at any time, and reading with rd_en_i low has no side effect.
- R11: A write to address 1 (alarm) changes neither the count nor the prescaler phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slow_tick_i | input | 1 | Slow-clock enable, one pulse per slow tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 divisor, 1 alarm, 2 interrupt enables |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe; a read of address 1 clears the flags |
| rd_addr_i | input | 2 | Read address: 0 count, 1 flags, 2 divisor, 3 alarm |
| rd_data_o | output | DATA_W | Combinational read data |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong prescaler phase appears at the count port within one divisor period: the count steps early or late relative to the tick total. A corrupted counter is visible on the very next read. A flag that fails to stick or to clear shows at the status read and at irq_o in the cycle after the offending edge. An alarm compare that is evaluated at the wrong time shows up when the bench holds the count on the alarm value with no ticks and checks that the flag stays clear. The sweep covers every divisor of a 3-bit prescaler through a full 6-bit wrap, so a miscount is caught within the sweep for that divisor.

// File: rtl/seconds_counter_pkg.sv
package seconds_counter_pkg;
  typedef enum logic [1:0] {
    WA_DIVISOR = 2'd0,
    WA_ALARM   = 2'd1,
    WA_IRQ_EN  = 2'd2,
    WA_NONE    = 2'd3
  } wr_addr_e;

  typedef enum logic [1:0] {
    RA_COUNT   = 2'd0,
    RA_STATUS  = 2'd1,
    RA_DIVISOR = 2'd2,
    RA_ALARM   = 2'd3
  } rd_addr_e;

  localparam int unsigned FLAG_INC   = 0;
  localparam int unsigned FLAG_ALARM = 1;
  localparam int unsigned NUM_FLAGS  = 2;
endpackage

// File: rtl/sc_prescaler.sv
module sc_prescaler #(
  parameter int unsigned PRE_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             step_o
);
  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] last_phase;
  logic             at_last;

  // div 0 wraps to all ones: a full 2^PRE_W period
  assign last_phase = div_i - 1'b1;
  assign at_last    = (phase_q == last_phase);
  assign step_o     = tick_i & at_last & ~restart_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        phase_q <= '0;
    else if (restart_i) phase_q <= '0;
    else if (tick_i)    phase_q <= at_last ? '0 : phase_q + 1'b1;
  end
endmodule

// File: rtl/sc_counter.sv
module sc_counter #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] alarm_i,
  output logic [CNT_W-1:0] count_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] count_nxt;

  assign count_nxt = count_q + 1'b1;
  // compare only on the advancing cycle: one hit per occurrence
  assign hit_o     = step_i & (count_nxt == alarm_i);
  assign count_o   = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        count_q <= '0;
    else if (restart_i) count_q <= '0;
    else if (step_i)    count_q <= count_nxt;
  end
endmodule

// File: rtl/sc_status.sv
module sc_status #(
  parameter int unsigned NF = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic          clr_i,
  input  logic [NF-1:0] en_i,
  output logic [NF-1:0] flags_o,
  output logic          irq_o
);
  logic [NF-1:0] flags_q;

  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flags_q[g] <= 1'b0;
      else         flags_q[g] <= set_i[g] | (flags_q[g] & ~clr_i);
    end
  end

  assign flags_o = flags_q;
  assign irq_o   = |(flags_q & en_i);
endmodule

// File: rtl/seconds_counter.sv
module seconds_counter
  import seconds_counter_pkg::*;
#(
  parameter int unsigned CNT_W   = 20,
  parameter int unsigned PRE_W   = 16,
  parameter int unsigned DATA_W  = 32,
  parameter logic [PRE_W-1:0] PRE_RST = 16'h8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_tick_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              irq_o
);
  localparam int unsigned NF = NUM_FLAGS;

  logic [PRE_W-1:0] div_q;
  logic [CNT_W-1:0] alarm_q;
  logic [NF-1:0]    irq_en_q;
  logic             pre_wr, alarm_wr, en_wr, sts_clr;
  logic             step_w, hit_w;
  logic [CNT_W-1:0] count_w;
  logic [NF-1:0]    flags_w, set_w;

  assign pre_wr   = wr_en_i & (wr_addr_e'(wr_addr_i) == WA_DIVISOR);
  assign alarm_wr = wr_en_i & (wr_addr_e'(wr_addr_i) == WA_ALARM);
  assign en_wr    = wr_en_i & (wr_addr_e'(wr_addr_i) == WA_IRQ_EN);
  assign sts_clr  = rd_en_i & (rd_addr_e'(rd_addr_i) == RA_STATUS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q    <= PRE_RST;
      alarm_q  <= '1;
      irq_en_q <= '0;
    end else begin
      if (pre_wr)   div_q    <= wr_data_i[PRE_W-1:0];
      if (alarm_wr) alarm_q  <= wr_data_i[CNT_W-1:0];
      if (en_wr)    irq_en_q <= wr_data_i[NF-1:0];
    end
  end

  sc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (slow_tick_i),
    .restart_i (pre_wr),
    .div_i     (div_q),
    .step_o    (step_w)
  );

  sc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step_w),
    .restart_i (pre_wr),
    .alarm_i   (alarm_q),
    .count_o   (count_w),
    .hit_o     (hit_w)
  );

  always_comb begin
    set_w             = '0;
    set_w[FLAG_INC]   = step_w;
    set_w[FLAG_ALARM] = hit_w;
  end

  sc_status #(.NF(NF)) u_sts (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_w),
    .clr_i   (sts_clr),
    .en_i    (irq_en_q),
    .flags_o (flags_w),
    .irq_o   (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_e'(rd_addr_i))
      RA_COUNT:   rd_data_o[CNT_W-1:0] = count_w;
      RA_STATUS:  rd_data_o[NF-1:0]    = flags_w;
      RA_DIVISOR: rd_data_o[PRE_W-1:0] = div_q;
      RA_ALARM:   rd_data_o[CNT_W-1:0] = alarm_q;
      default:    rd_data_o            = '0;
    endcase
  end
endmodule

// File: rtl/seconds_counter_chk.sv
module seconds_counter_chk #(
  parameter int unsigned CNT_W = 20,
  parameter int unsigned NF    = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             pre_wr_i,
  input logic             clr_i,
  input logic             step_i,
  input logic [CNT_W-1:0] count_i,
  input logic [CNT_W-1:0] alarm_i,
  input logic [NF-1:0]    flags_i,
  input logic             irq_i
);
  AST_STEP_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(count_i) |-> (count_i == $past(count_i) + 1'b1) || (count_i == '0)); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !pre_wr_i) |=> $stable(count_i)); // R2
  AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_wr_i |=> (count_i == '0)); // R5
  AST_INC_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> flags_i[0]); // R6
  AST_ALARM_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags_i[1]) |-> (count_i == $past(alarm_i))); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_i[1] && !clr_i) |=> flags_i[1]); // R8
  AST_IRQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (flags_i != '0)); // R9
endmodule

bind seconds_counter seconds_counter_chk #(.CNT_W(CNT_W), .NF(NF)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (slow_tick_i),
  .pre_wr_i (pre_wr),
  .clr_i    (sts_clr),
  .step_i   (step_w),
  .count_i  (count_w),
  .alarm_i  (alarm_q),
  .flags_i  (flags_w),
  .irq_i    (irq_o)
);

// File: tb/seconds_counter_tb.sv
`timescale 1ns/1ps
module seconds_counter_tb;
  localparam int CW = 6;
  localparam int PW = 3;
  localparam int WRAP = 1 << CW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, we = 1'b0, re = 1'b0;
  logic [1:0]  wa = '0, ra = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        irq;

  logic [1:0]  def_ra = '0;
  logic [31:0] def_rdata;
  logic        def_irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seconds_counter #(.CNT_W(CW), .PRE_W(PW), .DATA_W(32), .PRE_RST(3'd5)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(tick), .wr_en_i(we), .wr_addr_i(wa),
    .wr_data_i(wd), .rd_en_i(re), .rd_addr_i(ra), .rd_data_o(rdata), .irq_o(irq));

  seconds_counter u_dut_def (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(1'b1), .wr_en_i(1'b0), .wr_addr_i(2'd3),
    .wr_data_i(32'd0), .rd_en_i(1'b0), .rd_addr_i(def_ra), .rd_data_o(def_rdata),
    .irq_o(def_irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // at negedge: drive one cycle, return at next negedge
  task automatic cyc(input logic t, input logic w, input logic [1:0] a, input logic [31:0] d,
                     input logic r, input logic [1:0] rda);
    tick = t; we = w; wa = a; wd = d; re = r; ra = rda;
    @(posedge clk);
    @(negedge clk);
    tick = 0; we = 0; re = 0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    ra = a;
    #0.5;
    v = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 2'd3, 0, 1'b0, 2'd0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'd3, 0, 1'b0, 2'd0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cyc(1'b0, 1'b1, a, d, 1'b0, 2'd0);
  endtask

  task automatic clr_sts();
    cyc(1'b0, 1'b0, 2'd3, 0, 1'b1, 2'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int tcount;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    peek(2'd0, v); check("R1 count", v, 0);
    peek(2'd1, v); check("R1 flags", v, 0);
    peek(2'd2, v); check("R1 divisor", v, 5);
    peek(2'd3, v); check("R1 alarm", v, WRAP - 1);
    check("R1 irq", {31'd0, irq}, 0);
    def_ra = 2'd2; #0.5; check("R1 default divisor", def_rdata, 32'h8000);
    def_ra = 2'd3; #0.5; check("R1 default alarm", def_rdata, 32'hFFFFF);
    // R2 reset divisor of 5
    ticks(4); peek(2'd0, v); check("R2 before period", v, 0);
    idle(3);  peek(2'd0, v); check("R2 idle no effect", v, 0);
    ticks(1); peek(2'd0, v); check("R2 period done", v, 1);
    def_ra = 2'd0; #0.5; check("R1 default count holds", def_rdata, 0);

    // sweep every divisor through a wrap: R2 R3 R4 R10
    for (int d = 0; d < (1 << PW); d++) begin
      int eff;
      eff = (d == 0) ? (1 << PW) : d;
      wr(2'd0, d);
      peek(2'd2, v); check("R10 divisor readback", v, d);
      peek(2'd0, v); check("R5 count cleared", v, 0);
      tcount = 0;
      for (int i = 0; i < eff * (WRAP + 2) + 3; i++) begin
        logic t;
        t = (i % 3) != 2;
        cyc(t, 1'b0, 2'd3, 0, 1'b0, 2'd0);
        if (t) tcount++;
        peek(2'd0, v);
        check(d == 0 ? "R3 div0 sweep" : "R2 R4 sweep", v, (tcount / eff) % WRAP);
      end
    end

    // R5 restart clears phase, coincident tick lost
    wr(2'd0, 4);
    ticks(6); peek(2'd0, v); check("R5 pre", v, 1);
    cyc(1'b1, 1'b1, 2'd0, 4, 1'b0, 2'd0);
    peek(2'd0, v); check("R5 count cleared", v, 0);
    ticks(3); peek(2'd0, v); check("R5 phase restarted", v, 0);
    cyc(1'b1, 1'b1, 2'd0, 4, 1'b0, 2'd0);
    ticks(3); peek(2'd0, v); check("R5 coincident tick lost", v, 0);
    ticks(1); peek(2'd0, v); check("R5 first step", v, 1);

    // R11 alarm write keeps phase
    wr(2'd0, 4);
    ticks(2);
    cyc(1'b1, 1'b1, 2'd1, 50, 1'b0, 2'd0);
    peek(2'd3, v); check("R10 alarm readback", v, 50);
    peek(2'd0, v); check("R11 count kept", v, 0);
    ticks(1); peek(2'd0, v); check("R11 phase kept", v, 1);

    // R6 R8 R9 flags and interrupt
    wr(2'd2, 0);
    wr(2'd0, 1);
    clr_sts();
    peek(2'd1, v); check("R8 cleared", v, 0);
    check("R9 irq low", {31'd0, irq}, 0);
    ticks(1);
    peek(2'd1, v); check("R6 inc flag", v, 1);
    peek(2'd1, v); check("R10 plain read no clear", v, 1);
    check("R9 masked", {31'd0, irq}, 0);
    wr(2'd2, 1);
    check("R9 enabled", {31'd0, irq}, 1);
    clr_sts();
    peek(2'd1, v); check("R8 read clears", v, 0);
    check("R9 irq drops", {31'd0, irq}, 0);
    cyc(1'b1, 1'b0, 2'd3, 0, 1'b1, 2'd1);
    peek(2'd1, v); check("R8 set wins over clear", v, 1);
    peek(2'd0, v); check("R6 count", v, 2);
    wr(2'd2, 2);
    check("R9 other enable only", {31'd0, irq}, 0);

    // R7 alarm once per occurrence
    wr(2'd1, 5);
    clr_sts();
    ticks(2); peek(2'd1, v); check("R7 no early alarm", v & 2, 0);
    ticks(1); peek(2'd1, v); check("R7 alarm set", v & 2, 2);
    check("R9 alarm irq", {31'd0, irq}, 1);
    clr_sts();
    idle(5); peek(2'd1, v); check("R7 no repeat while held", v, 0);
    check("R9 irq low after clear", {31'd0, irq}, 0);
    ticks(1); peek(2'd1, v); check("R7 past alarm", v & 2, 0);
    ticks(WRAP - 2); peek(2'd1, v); check("R7 before next match", v & 2, 0);
    ticks(1); peek(2'd1, v); check("R7 next occurrence", v & 2, 2);
    peek(2'd0, v); check("R4 wrapped count", v, 5);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule